// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns a small set of external interrupt pins into one prioritised interrupt request for a processor core. Every pin passes through a clock-domain synchroniser. A further register keeps the previous synchronised sample. A two-bit sense code per pin picks the trigger: a held low level, any change, a falling edge or a rising edge.

Edge and change events set a sticky per-pin flag. Software clears a flag by writing a one to its bit, or the core clears it by acknowledging that pin's interrupt. Low-level mode keeps no flag: the request follows the synchronised pin and falls as soon as the pin returns high. A pin's request is forwarded only while the global enable input and that pin's enable bit are both set. Among the forwarded requests the lowest-numbered pin wins.

The sense codes and enable bits are loaded together through a single write strobe. All state resets synchronously. After reset the synchronisers hold the idle-high value, so a pin that is already high produces no edge.

Top module: `eisc_top`

## Requirements
- R1: After reset `irq_o` and `flag_o` are 0, every sense code is 00 and every enable bit is 0. With `gie_i`=1, a low pin then raises no request.
- R2: Sense code 00 (low level) gives a request while the synchronised pin is low. Take a pin driven low before rising edge E1. `irq_o` is 1 after edge E3 and not after E2, and it stays 1 while the pin stays low.
- R3: Sense code 01 sets the pin's flag on every change of the pin, both falling and rising. A change sampled at E1 makes the flag visible after E3 and `irq_o` after E4.
- R4: Sense code 10 sets the flag on a falling edge, with the R3 timing. A rising edge leaves the flag at 0.
- R5: Sense code 11 sets the flag on a rising edge, with the R3 timing. A falling edge leaves the flag at 0.
- R6: In edge modes, a pulse held for one full clock period, so that it spans one rising edge, sets the flag.
- R7: A pin's request reaches `irq_o` only while both `gie_i` and its enable bit are 1. Flags still set while the request is masked. After a change to either enable, `irq_o` follows one cycle later.
- R8: A flag clears one cycle after `flag_clr_i` has a 1 in its bit position, or after `ack_i`=1 with `ack_id_i` equal to the pin index. A flag event in the same cycle as a clear wins, and the flag reads 1.
- R9: When more than one forwarded request is active, `irq_id_o` gives the lowest pin index, one cycle after the requests.
- R10: Low-level mode is not latched. `flag_o` stays 0 in this mode. `irq_o` returns to 0 after the third rising edge after the pin goes high.
- R11: `cfg_sense_i` holds the code for pin i in bits [2i+1:2i], and `cfg_en_i` bit i is the enable for pin i. Both are loaded at the rising edge where `cfg_we_i`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | External interrupt pins, asynchronous to clk |
| gie_i | input | 1 | Global interrupt enable from the core |
| cfg_we_i | input | 1 | Load strobe for the sense codes and enable bits |
| cfg_sense_i | input | 2*NPIN | Sense codes, two bits per pin |
| cfg_en_i | input | NPIN | Per-pin enable bits |
| flag_clr_i | input | NPIN | Write-one-to-clear mask for the flags |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| ack_id_i | input | IDW | Index of the pin being acknowledged |
| irq_o | output | 1 | Registered interrupt request |
| irq_id_o | output | IDW | Registered index of the winning pin |
| flag_o | output | NPIN | Per-pin event flags |

## Verification
A wrong synchroniser or previous-sample state shows at the ports as a request that arrives one cycle early or late. It can also show as an edge that should not be there, for example a rising-edge flag caused by a falling pin. Every pin change is therefore checked at the exact cycle where `flag_o` and `irq_o` must change, and also one cycle before. A stuck or lost flag shows within two cycles of a clear or acknowledge, as `irq_o` staying high or `irq_id_o` failing to move to the next pin. A corrupted sense code shows within four cycles of the next pin change.

// File: rtl/eisc_pkg.sv
`timescale 1ns/1ps
package eisc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eisc_sync.sv
`timescale 1ns/1ps
module eisc_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic cur_o,
  output logic prev_o
);
  logic meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      cur_q  <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eisc_detect.sv
`timescale 1ns/1ps
module eisc_detect
  import eisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cur_i,
  input  logic   prev_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o
);
  logic evt;
  logic flag_q;

  always_comb begin
    unique case (sense_i)
      SENSE_ANY:  evt = cur_i ^ prev_i;
      SENSE_FALL: evt = prev_i & ~cur_i;
      SENSE_RISE: evt = ~prev_i & cur_i;
      default:    evt = 1'b0;
    endcase
  end

  // a new event beats a clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (evt)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = (sense_i == SENSE_LOW) ? ~cur_i : flag_q;

  p_level_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_LOW && !flag_q) |=> !flag_q);
  p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt) |=> !flag_q);
endmodule

// File: rtl/eisc_prio.sv
`timescale 1ns/1ps
module eisc_prio #(
  parameter int NPIN = 2,
  parameter int IDW  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] req_i,
  output logic            irq_o,
  output logic [IDW-1:0]  id_o
);
  logic           any;
  logic [IDW-1:0] pick;
  logic           irq_q;
  logic [IDW-1:0] id_q;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any  = 1'b1;
        pick = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= any;
      id_q  <= pick;
    end
  end

  assign irq_o = irq_q;
  assign id_o  = id_q;

  p_low_index_wins_r9: assert property (@(posedge clk) disable iff (rst)
    req_i[0] |=> (irq_q && id_q == '0));
endmodule

// File: rtl/eisc_top.sv
`timescale 1ns/1ps
module eisc_top
  import eisc_pkg::*;
#(
  parameter int NPIN = 2,
  localparam int IDW = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              gie_i,
  input  logic              cfg_we_i,
  input  logic [2*NPIN-1:0] cfg_sense_i,
  input  logic [NPIN-1:0]   cfg_en_i,
  input  logic [NPIN-1:0]   flag_clr_i,
  input  logic              ack_i,
  input  logic [IDW-1:0]    ack_id_i,
  output logic              irq_o,
  output logic [IDW-1:0]    irq_id_o,
  output logic [NPIN-1:0]   flag_o
);
  logic [2*NPIN-1:0] sense_q;
  logic [NPIN-1:0]   en_q;
  logic [NPIN-1:0]   req_raw;
  logic [NPIN-1:0]   req_fwd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      en_q    <= '0;
    end else if (cfg_we_i) begin
      sense_q <= cfg_sense_i;
      en_q    <= cfg_en_i;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    localparam logic [IDW-1:0] MY_ID = IDW'(g);
    logic cur, prev, clr;

    assign clr = flag_clr_i[g] | (ack_i && ack_id_i == MY_ID);

    eisc_sync #(.RST_VAL(1'b1)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (pin_i[g]),
      .cur_o  (cur),
      .prev_o (prev)
    );

    eisc_detect u_det (
      .clk     (clk),
      .rst     (rst),
      .cur_i   (cur),
      .prev_i  (prev),
      .sense_i (sense_e'(sense_q[2*g +: 2])),
      .clr_i   (clr),
      .flag_o  (flag_o[g]),
      .req_o   (req_raw[g])
    );
  end

  assign req_fwd = req_raw & en_q & {NPIN{gie_i}};

  eisc_prio #(.NPIN(NPIN), .IDW(IDW)) u_prio (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_fwd),
    .irq_o (irq_o),
    .id_o  (irq_id_o)
  );

  p_global_mask_r7: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_o);
  p_pin_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && !cfg_we_i) |=> !irq_o);
endmodule

// File: tb/sim_eisc_top.sv
`timescale 1ns/1ps
module sim_eisc_top;
  localparam int NPIN = 2;
  localparam int IDW  = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIN-1:0] pin_i = 2'b11;
  logic            gie_i = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic [3:0]      cfg_sense_i = '0;
  logic [NPIN-1:0] cfg_en_i = '0;
  logic [NPIN-1:0] flag_clr_i = '0;
  logic            ack_i = 1'b0;
  logic [IDW-1:0]  ack_id_i = '0;
  logic            irq_o;
  logic [IDW-1:0]  irq_id_o;
  logic [NPIN-1:0] flag_o;

  eisc_top #(.NPIN(NPIN)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .gie_i(gie_i),
    .cfg_we_i(cfg_we_i), .cfg_sense_i(cfg_sense_i), .cfg_en_i(cfg_en_i),
    .flag_clr_i(flag_clr_i), .ack_i(ack_i), .ack_id_i(ack_id_i),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .flag_o(flag_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         cyc;
    bit         irq;
    int         id;
    bit [1:0]   flg;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations at their target cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || irq_o !== e.irq || (e.irq && int'(irq_id_o) != e.id)
          || flag_o !== e.flg) begin
        errors++;
        $display("FAIL %s: irq=%0b id=%0d flags=%b expected irq=%0b id=%0d flags=%b",
                 e.tag, irq_o, irq_id_o, flag_o, e.irq, e.id, e.flg);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input bit irq, input int id,
                           input bit [1:0] f, input string tag);
    exp_t it;
    it.cyc = cyc + d; it.irq = irq; it.id = id; it.flg = f; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg(input bit [3:0] sense, input bit [1:0] en);
    cfg_sense_i = sense; cfg_en_i = en; cfg_we_i = 1'b1;
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear(input bit [1:0] m);
    flag_clr_i = m;
    tick(1);
    flag_clr_i = '0;
    tick(3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    expect_at(1, 0, 0, 2'b00, "R1 reset outputs");
    tick(2);
    // R1: default level mode but enables are 0
    gie_i = 1'b1;
    pin_i = 2'b10;
    expect_at(3, 0, 0, 2'b00, "R1 default enables off");
    expect_at(5, 0, 0, 2'b00, "R1 default enables off late");
    tick(5);
    pin_i = 2'b11;
    tick(4);

    // R2 / R10: low level on pin0 (R11 field layout)
    cfg(4'b0000, 2'b01);
    pin_i = 2'b10;
    expect_at(2, 0, 0, 2'b00, "R2 before sync");
    expect_at(3, 1, 0, 2'b00, "R2 level request");
    expect_at(5, 1, 0, 2'b00, "R2 held");
    tick(6);
    pin_i = 2'b11;
    expect_at(2, 1, 0, 2'b00, "R10 release in flight");
    expect_at(3, 0, 0, 2'b00, "R10 not latched");
    tick(5);

    // R5 / R7: pin1 rising, enable off
    cfg(4'b1100, 2'b00);
    pin_i = 2'b01;
    expect_at(4, 0, 0, 2'b00, "R5 falling ignored");
    tick(5);
    pin_i = 2'b11;
    expect_at(2, 0, 0, 2'b00, "R5 before flag");
    expect_at(3, 0, 0, 2'b10, "R5 rising sets flag");
    expect_at(4, 0, 0, 2'b10, "R7 pin enable masks");
    tick(5);
    cfg(4'b1100, 2'b10);
    expect_at(1, 1, 1, 2'b10, "R7 both enables");
    tick(2);
    gie_i = 1'b0;
    expect_at(1, 0, 0, 2'b10, "R7 global mask");
    tick(2);
    gie_i = 1'b1;
    expect_at(1, 1, 1, 2'b10, "R7 global restored");
    tick(2);

    // R4 / R9: pin0 falling while pin1 pending
    cfg(4'b1110, 2'b11);
    pin_i = 2'b10;
    expect_at(3, 1, 1, 2'b11, "R4 falling sets flag");
    expect_at(4, 1, 0, 2'b11, "R9 pin0 wins");
    tick(5);

    // R8: acknowledge pin0, then write-one-to-clear pin1
    ack_i = 1'b1; ack_id_i = 1'b0;
    expect_at(1, 1, 0, 2'b10, "R8 ack clears flag");
    expect_at(2, 1, 1, 2'b10, "R9 next pin after ack");
    tick(1);
    ack_i = 1'b0;
    tick(2);
    flag_clr_i = 2'b10;
    expect_at(1, 1, 1, 2'b00, "R8 w1c clears flag");
    expect_at(2, 0, 0, 2'b00, "R8 w1c drops request");
    tick(1);
    flag_clr_i = '0;
    tick(2);

    // R4: rising ignored in falling mode
    pin_i = 2'b11;
    expect_at(4, 0, 0, 2'b00, "R4 rising ignored");
    tick(5);

    // R3: any change on pin1
    cfg(4'b0110, 2'b10);
    pin_i = 2'b01;
    expect_at(3, 0, 0, 2'b10, "R3 fall sets flag");
    expect_at(4, 1, 1, 2'b10, "R3 fall request");
    tick(5);
    clear(2'b10);
    pin_i = 2'b11;
    expect_at(2, 0, 0, 2'b00, "R3 before rise flag");
    expect_at(3, 0, 0, 2'b10, "R3 rise sets flag");
    tick(4);
    clear(2'b10);

    // R6: one-period pulse in rising mode on pin0
    cfg(4'b0111, 2'b01);
    pin_i = 2'b10;
    tick(4);
    pin_i = 2'b11;
    expect_at(3, 0, 0, 2'b01, "R6 short pulse flag");
    expect_at(4, 1, 0, 2'b01, "R6 short pulse request");
    tick(1);
    pin_i = 2'b10;
    tick(5);
    clear(2'b01);

    // R8: event and clear in the same cycle
    pin_i = 2'b11;
    expect_at(3, 0, 0, 2'b01, "R8 set beats clear");
    expect_at(4, 1, 0, 2'b01, "R8 set beats clear request");
    tick(2);
    flag_clr_i = 2'b01;
    tick(1);
    flag_clr_i = '0;
    tick(5);

    while (q.size() > 0) tick(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL timeout: cycles %0d expected under %0d", cyc, 5000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule